// File: doc/BRIEF.md
# Burst Offset Sequencer

This block generates the low-order word offset within a four-beat burst of a synchronous memory. A load command captures the two least significant bits of the external address as the starting offset. Each later advance command steps the offset to the next location of the burst. A static order input selects how the offset steps: in linear order it counts up and wraps modulo four, and in interleaved order it is the start offset XORed with a running step count. After four advances the offset returns to the start.

Every command is qualified by an active-low clock enable. While that enable is deasserted, the sequencer keeps its state and ignores all other inputs. The offset output is registered. It changes one clock after the qualifying edge, so downstream address logic can use it directly. The offset width is a parameter with a default of two bits.

Top module: `burst_addr_seq`

## Requirements
- R1: A synchronous active-high reset sets the offset output to 0 one clock later.
- R2: When `clk_en_n`=0 and `adv_ld`=0 at a rising edge, the offset output equals the sampled `ld_addr` after that edge. This holds in both orders.
- R3: When `clk_en_n`=0 and `adv_ld`=1 at a rising edge, the internal step count increments by one and the offset moves to the next burst location.
- R4: With `order_sel`=0 (linear), the offsets after a load of start s and then 0, 1, 2 and 3 advances are s, s+1, s+2 and s+3, modulo 4.
- R5: With `order_sel`=1 (interleaved), the offsets after a load of start s and then 0, 1, 2 and 3 advances are s^0, s^1, s^2 and s^3.
- R6: The fourth advance after a load returns the offset to the start value s, in both orders.
- R7: When `clk_en_n`=1 at a rising edge, the offset and the burst state keep their values, and `adv_ld` and `ld_addr` are ignored.
- R8: A load issued in the middle of a burst clears the step count, so the next advance yields the first step from the new start.
- R9: Reset takes priority over a simultaneous load or advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| clk_en_n | input | 1 | Clock qualifier, active low |
| adv_ld | input | 1 | 1 = advance the burst, 0 = load a new start |
| ld_addr | input | OFS_W | Low address bits captured on a load |
| order_sel | input | 1 | 0 = linear order, 1 = interleaved order |
| ofs | output | OFS_W | Registered current burst offset |

## Verification
Every start offset from 0 to 3 is loaded in both orders and followed by four advances. This separates linear stepping from interleaved stepping: the two orders match for start 0 and differ for odd starts. The fourth advance of each burst checks the wrap back to the start. Cycles with the enable deasserted and changing address and command inputs confirm the hold behaviour. A reload in the middle of a burst shows whether the step count restarts. A reset asserted together with a load shows which of the two wins.

// File: rtl/burst_pkg.sv
package burst_pkg;
  localparam int unsigned DEF_OFS_W = 2;

  typedef enum logic [1:0] {
    CMD_HOLD = 2'd0,
    CMD_LOAD = 2'd1,
    CMD_ADV  = 2'd2
  } burst_cmd_e;

  typedef enum logic {
    ORDER_LINEAR      = 1'b0,
    ORDER_INTERLEAVED = 1'b1
  } burst_order_e;
endpackage

// File: rtl/burst_cmd_dec.sv
module burst_cmd_dec
  import burst_pkg::*;
(
  input  logic       clk_en_n,
  input  logic       adv_ld,
  output burst_cmd_e cmd
);
  always_comb begin
    if (clk_en_n)    cmd = CMD_HOLD;
    else if (adv_ld) cmd = CMD_ADV;
    else             cmd = CMD_LOAD;
  end
endmodule

// File: rtl/burst_step_cnt.sv
module burst_step_cnt
  import burst_pkg::*;
#(
  parameter int unsigned OFS_W = DEF_OFS_W
) (
  input  logic             clk,
  input  logic             rst,
  input  burst_cmd_e       cmd,
  input  logic [OFS_W-1:0] ld_addr,
  output logic [OFS_W-1:0] base_nxt,
  output logic [OFS_W-1:0] cnt_nxt
);
  localparam logic [OFS_W-1:0] ONE = OFS_W'(1);

  logic [OFS_W-1:0] base_q;
  logic [OFS_W-1:0] cnt_q;

  always_comb begin
    base_nxt = base_q;
    cnt_nxt  = cnt_q;
    unique case (cmd)
      CMD_LOAD: begin
        base_nxt = ld_addr;
        cnt_nxt  = '0;
      end
      CMD_ADV:  cnt_nxt = cnt_q + ONE;
      default:  ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else begin
      base_q <= base_nxt;
      cnt_q  <= cnt_nxt;
    end
  end

  assert_step_inc_R3: assert property (@(posedge clk) disable iff (rst)
    cmd == CMD_ADV |=> cnt_q == $past(cnt_q) + ONE);

  assert_load_clears_R8: assert property (@(posedge clk) disable iff (rst)
    cmd == CMD_LOAD |=> (cnt_q == '0) && (base_q == $past(ld_addr)));
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_pkg::*;
#(
  parameter int unsigned OFS_W = DEF_OFS_W
) (
  input  logic [OFS_W-1:0] base,
  input  logic [OFS_W-1:0] cnt,
  input  burst_order_e     order,
  output logic [OFS_W-1:0] ofs
);
  logic [OFS_W-1:0] lin_ofs;
  logic [OFS_W-1:0] ilv_ofs;

  assign lin_ofs = base + cnt;

  for (genvar b = 0; b < OFS_W; b++) begin : g_ilv
    assign ilv_ofs[b] = base[b] ^ cnt[b];
  end

  assign ofs = (order == ORDER_INTERLEAVED) ? ilv_ofs : lin_ofs;
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_pkg::*;
#(
  parameter int unsigned OFS_W = DEF_OFS_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clk_en_n,
  input  logic             adv_ld,
  input  logic [OFS_W-1:0] ld_addr,
  input  logic             order_sel,
  output logic [OFS_W-1:0] ofs
);
  burst_cmd_e       cmd;
  burst_order_e     order;
  logic [OFS_W-1:0] base_nxt;
  logic [OFS_W-1:0] cnt_nxt;
  logic [OFS_W-1:0] ofs_nxt;
  logic [OFS_W-1:0] ofs_q;

  assign order = burst_order_e'(order_sel);

  burst_cmd_dec u_dec (
    .clk_en_n (clk_en_n),
    .adv_ld   (adv_ld),
    .cmd      (cmd)
  );

  burst_step_cnt #(.OFS_W(OFS_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .cmd      (cmd),
    .ld_addr  (ld_addr),
    .base_nxt (base_nxt),
    .cnt_nxt  (cnt_nxt)
  );

  burst_order_map #(.OFS_W(OFS_W)) u_map (
    .base  (base_nxt),
    .cnt   (cnt_nxt),
    .order (order),
    .ofs   (ofs_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst)                 ofs_q <= '0;
    else if (cmd != CMD_HOLD) ofs_q <= ofs_nxt;
  end

  assign ofs = ofs_q;

  assert_reset_zero_R1: assert property (@(posedge clk)
    rst |=> ofs == '0);

  assert_load_start_R2: assert property (@(posedge clk) disable iff (rst)
    (!clk_en_n && !adv_ld) |=> ofs == $past(ld_addr));

  assert_hold_stable_R7: assert property (@(posedge clk) disable iff (rst)
    clk_en_n |=> $stable(ofs));
endmodule

// File: tb/sim_burst_addr_seq.sv
module sim_burst_addr_seq;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       clk_en_n = 1'b1;
  logic       adv_ld = 1'b0;
  logic [1:0] ld_addr = 2'd0;
  logic       order_sel = 1'b0;
  logic [1:0] ofs;

  typedef struct {
    logic [1:0] exp;
    string      tag;
  } item_t;

  item_t sb[$];
  int    n_run  = 0;
  int    n_fail = 0;
  bit    done   = 0;

  always #2 clk = ~clk;

  burst_addr_seq #(.OFS_W(2)) u0 (
    .clk       (clk),
    .rst       (rst),
    .clk_en_n  (clk_en_n),
    .adv_ld    (adv_ld),
    .ld_addr   (ld_addr),
    .order_sel (order_sel),
    .ofs       (ofs)
  );

  task automatic drive(input logic r, input logic en_n, input logic adv,
                       input logic [1:0] a, input logic m,
                       input logic [1:0] e, input string tag);
    item_t it;
    @(negedge clk);
    rst = r; clk_en_n = en_n; adv_ld = adv; ld_addr = a; order_sel = m;
    it.exp = e; it.tag = tag;
    sb.push_back(it);
  endtask

  function automatic logic [1:0] ref_ofs(input logic m, input logic [1:0] s, input int k);
    return m ? (s ^ 2'(k)) : 2'(s + 2'(k));
  endfunction

  initial begin : monitor
    item_t it;
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        it = sb.pop_front();
        n_run++;
        if (ofs !== it.exp) begin
          n_fail++;
          $display("FAIL %s ofs actual=%0d expected=%0d", it.tag, ofs, it.exp);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (10000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R3 watchdog actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : stim
    // R1: reset state
    drive(1, 1, 0, 2'd0, 0, 2'd0, "R1");
    drive(1, 0, 1, 2'd3, 0, 2'd0, "R1");
    // R4 / R5 / R6: every start offset in both orders
    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 4; s++) begin
        drive(0, 0, 0, 2'(s), 1'(m), 2'(s), "R2");
        for (int k = 1; k <= 4; k++) begin
          drive(0, 0, 1, 2'(3 - s), 1'(m), ref_ofs(1'(m), 2'(s), k),
                (k == 4) ? "R6" : (k == 1) ? "R3" : (m == 1) ? "R5" : "R4");
        end
      end
    end
    // R7: enable deasserted, command and address wiggle
    drive(0, 0, 0, 2'd1, 1, 2'd1, "R2");
    drive(0, 0, 1, 2'd0, 1, 2'd0, "R5");
    drive(0, 1, 0, 2'd2, 1, 2'd0, "R7");
    drive(0, 1, 1, 2'd3, 1, 2'd0, "R7");
    drive(0, 0, 1, 2'd2, 1, 2'd3, "R5");
    // R8: reload mid-burst restarts count
    drive(0, 0, 0, 2'd2, 0, 2'd2, "R8");
    drive(0, 0, 1, 2'd0, 0, 2'd3, "R8");
    drive(0, 0, 0, 2'd2, 1, 2'd2, "R8");
    drive(0, 0, 1, 2'd0, 1, 2'd3, "R8");
    // R9: reset beats a simultaneous load, then an advance from zero state
    drive(1, 0, 0, 2'd3, 0, 2'd0, "R9");
    drive(0, 0, 1, 2'd3, 0, 2'd1, "R9");
    drive(0, 1, 1, 2'd0, 0, 2'd1, "R7");
    repeat (3) @(negedge clk);
    if (sb.size() != 0) begin
      n_fail++;
      $display("FAIL R3 scoreboard actual=%0d expected=0 pending", sb.size());
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule